// File: doc/BRIEF.md
# EEPROM Address Pointer with Page-Wrapping Increment

This block keeps the byte address for a serial EEPROM core. The array holds 2048 bytes. It is split into 64 pages, and each page holds 32 bytes. The bus front end loads two fields of the address:

- the three high bits, when the device-select byte completes;
- the eight low bits, when the word-address byte completes.

The front end then pulses a step strobe one clock after each data byte.

The step rule depends on the transfer direction:

- **Writing:** only the byte-within-page field counts up. The count rolls over inside the same page, and the page number never moves.
- **Reading:** the whole address counts up and crosses page and block boundaries. After the last byte it rolls back to zero.

A read that starts without a fresh word address simply continues from the value held. The pointer keeps its value between strobes.

Top module: `eep_addr_pointer`

## Requirements
- R1: While `rst_n` is low, `addr` is 0.
- R2: A `blk_load` pulse places `blk_val` in `addr[10:8]` after the next rising clock edge.
  - If `word_load` is not also high, `addr[7:0]` keeps its value.
- R3: A `word_load` pulse places `word_val` in `addr[7:0]` after the next rising clock edge.
  - If `blk_load` is not also high, `addr[10:8]` keeps its value.
- R4: A `step` pulse with `rd_mode` = 0 and no load adds one to `addr[4:0]` modulo 32.
  - `addr[10:5]` stays unchanged.
  - For example, 31 becomes 0 and 63 becomes 32.
- R5: A `step` pulse with `rd_mode` = 1 and no load adds one to the full 11-bit `addr` modulo 2048.
  - It carries across page and block boundaries.
  - 2047 becomes 0.
- R6: With `blk_load`, `word_load` and `step` all low, `addr` holds its value whatever `rd_mode`, `blk_val` and `word_val` do.
  - A later read therefore resumes from the held pointer.
- R7: When `step` is high in the same cycle as either load strobe, the step is ignored.
  - Only the load takes effect.
- R8: When `blk_load` and `word_load` are both high in one cycle, both fields take their new values together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_load | input | 1 | Loads the block field from `blk_val` |
| blk_val | input | 3 | Block number taken from the device-select byte |
| word_load | input | 1 | Loads the low field from `word_val` |
| word_val | input | 8 | Word address byte |
| step | input | 1 | Advance strobe, one clock after each data byte |
| rd_mode | input | 1 | 1 = read transfer (linear count), 0 = write transfer (in-page count) |
| addr | output | 11 | Current byte address |

## Verification
Every state bit of this block is the output, so a wrong internal value shows on `addr` in the cycle right after the offending edge. The sensitive points are carries at bit 4 and at bit 10:

- During writes, a carry leaking from bit 4 into bit 5 would move the page number one step too early.
- During reads, a missing carry would repeat a page.

For this reason the vectors land the pointer on 31, on 63, on 255 and on 2047 before each step. Full walks of one page and of the whole array then confirm that the count returns to its start value after 32 and after 2048 steps.

// File: rtl/eep_ptr_pkg.sv
package eep_ptr_pkg;

   // transfer direction as seen by the pointer
   typedef enum logic {
      PTR_WRITE = 1'b0,
      PTR_READ  = 1'b1
   } ptr_mode_e;

   // one action per clock, decided by priority
   typedef enum logic [1:0] {
      ACT_HOLD   = 2'd0,
      ACT_LOAD   = 2'd1,
      ACT_PAGE   = 2'd2,
      ACT_LINEAR = 2'd3
   } ptr_act_e;

   typedef struct packed {
      logic      blk_ld;
      logic      word_ld;
      logic      step;
      ptr_mode_e mode;
   } ptr_cmd_t;

endpackage

// File: rtl/eep_ptr_decode.sv
module eep_ptr_decode
   import eep_ptr_pkg::*;
(
   input  ptr_cmd_t cmd,
   output ptr_act_e act
);

   // loads outrank the step strobe; step picks its rule from the mode
   always_comb begin
      act = ACT_HOLD;
      if (cmd.blk_ld || cmd.word_ld) begin
         act = ACT_LOAD;
      end else if (cmd.step) begin
         act = (cmd.mode == PTR_READ) ? ACT_LINEAR : ACT_PAGE;
      end
   end

endmodule

// File: rtl/eep_ptr_incr.sv
module eep_ptr_incr #(
   parameter int ADDR_W = 11,
   parameter int PAGE_W = 5
) (
   input  logic [ADDR_W-1:0] cur,
   output logic [ADDR_W-1:0] lin_next,
   output logic [ADDR_W-1:0] page_next
);

   localparam int HI_W = ADDR_W - PAGE_W;

   assign lin_next = cur + ADDR_W'(1);

   generate
      if (HI_W == 0) begin : g_single_page
         // the page covers the whole array: both rules coincide
         assign page_next = lin_next;
      end else begin : g_paged
         logic [PAGE_W-1:0] lo_next;
         assign lo_next   = cur[PAGE_W-1:0] + PAGE_W'(1);
         assign page_next = {cur[ADDR_W-1:PAGE_W], lo_next};
      end
   endgenerate

endmodule

// File: rtl/eep_ptr_store.sv
module eep_ptr_store
   import eep_ptr_pkg::*;
#(
   parameter int BLK_W  = 3,
   parameter int WORD_W = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  ptr_act_e                 act,
   input  logic                     blk_ld,
   input  logic                     word_ld,
   input  logic [BLK_W-1:0]         blk_val,
   input  logic [WORD_W-1:0]        word_val,
   input  logic [BLK_W+WORD_W-1:0]  lin_next,
   input  logic [BLK_W+WORD_W-1:0]  page_next,
   output logic [BLK_W+WORD_W-1:0]  q
);

   localparam int ADDR_W = BLK_W + WORD_W;

   logic [ADDR_W-1:0] d;

   always_comb begin
      d = q;
      unique case (act)
         ACT_LOAD: begin
            if (blk_ld)  d[ADDR_W-1:WORD_W] = blk_val;
            if (word_ld) d[WORD_W-1:0]      = word_val;
         end
         ACT_PAGE:   d = page_next;
         ACT_LINEAR: d = lin_next;
         default:    d = q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
   end

endmodule

// File: rtl/eep_addr_pointer.sv
module eep_addr_pointer
   import eep_ptr_pkg::*;
#(
   parameter int BLK_W  = 3,
   parameter int WORD_W = 8,
   parameter int PAGE_W = 5
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    blk_load,
   input  logic [BLK_W-1:0]        blk_val,
   input  logic                    word_load,
   input  logic [WORD_W-1:0]       word_val,
   input  logic                    step,
   input  logic                    rd_mode,
   output logic [BLK_W+WORD_W-1:0] addr
);

   localparam int ADDR_W = BLK_W + WORD_W;

   generate
      if (BLK_W < 1) begin : g_bad_blk
         $error("eep_addr_pointer: BLK_W must be at least 1");
      end
      if (PAGE_W < 1 || PAGE_W > WORD_W) begin : g_bad_page
         $error("eep_addr_pointer: PAGE_W must lie in 1..WORD_W");
      end
   endgenerate

   ptr_cmd_t          cmd;
   ptr_act_e          act;
   logic [ADDR_W-1:0] lin_next;
   logic [ADDR_W-1:0] page_next;

   assign cmd.blk_ld  = blk_load;
   assign cmd.word_ld = word_load;
   assign cmd.step    = step;
   assign cmd.mode    = rd_mode ? PTR_READ : PTR_WRITE;

   eep_ptr_decode u_decode (
      .cmd (cmd),
      .act (act)
   );

   eep_ptr_incr #(
      .ADDR_W (ADDR_W),
      .PAGE_W (PAGE_W)
   ) u_incr (
      .cur       (addr),
      .lin_next  (lin_next),
      .page_next (page_next)
   );

   eep_ptr_store #(
      .BLK_W  (BLK_W),
      .WORD_W (WORD_W)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .act       (act),
      .blk_ld    (blk_load),
      .word_ld   (word_load),
      .blk_val   (blk_val),
      .word_val  (word_val),
      .lin_next  (lin_next),
      .page_next (page_next),
      .q         (addr)
   );

endmodule

// File: rtl/eep_addr_pointer_chk.sv
module eep_addr_pointer_chk #(
   parameter int BLK_W  = 3,
   parameter int WORD_W = 8,
   parameter int PAGE_W = 5
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    blk_load,
   input logic [BLK_W-1:0]        blk_val,
   input logic                    word_load,
   input logic [WORD_W-1:0]       word_val,
   input logic                    step,
   input logic                    rd_mode,
   input logic [BLK_W+WORD_W-1:0] addr
);

   localparam int ADDR_W = BLK_W + WORD_W;

   logic              any_ld;
   logic [PAGE_W-1:0] lo_plus;
   logic [ADDR_W-1:0] all_plus;

   assign any_ld   = blk_load | word_load;
   assign lo_plus  = addr[PAGE_W-1:0] + PAGE_W'(1);
   assign all_plus = addr + ADDR_W'(1);

   // R1
   assert_reset_zero_R1: assert property (@(posedge clk)
      !rst_n |=> addr == '0);

   // R2
   assert_blk_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      blk_load |=> addr[ADDR_W-1:WORD_W] == $past(blk_val));

   // R2
   assert_blk_keeps_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_load && !word_load) |=> addr[WORD_W-1:0] == $past(addr[WORD_W-1:0]));

   // R3
   assert_word_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      word_load |=> addr[WORD_W-1:0] == $past(word_val));

   // R3
   assert_word_keeps_blk_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (word_load && !blk_load) |=> addr[ADDR_W-1:WORD_W] == $past(addr[ADDR_W-1:WORD_W]));

   // R4
   assert_page_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !rd_mode && !any_ld) |=> $stable(addr[ADDR_W-1:PAGE_W]));

   // R4
   assert_page_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !rd_mode && !any_ld) |=> addr[PAGE_W-1:0] == $past(lo_plus));

   // R5
   assert_linear_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (step && rd_mode && !any_ld) |=> addr == $past(all_plus));

   // R6
   assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !any_ld) |=> $stable(addr));

endmodule

bind eep_addr_pointer eep_addr_pointer_chk #(
   .BLK_W  (BLK_W),
   .WORD_W (WORD_W),
   .PAGE_W (PAGE_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .blk_load  (blk_load),
   .blk_val   (blk_val),
   .word_load (word_load),
   .word_val  (word_val),
   .step      (step),
   .rd_mode   (rd_mode),
   .addr      (addr)
);

// File: tb/eep_addr_pointer_test.sv
module eep_addr_pointer_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        blk_load = 1'b0;
   logic [2:0]  blk_val = 3'd0;
   logic        word_load = 1'b0;
   logic [7:0]  word_val = 8'd0;
   logic        step = 1'b0;
   logic        rd_mode = 1'b0;
   logic [10:0] addr;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   eep_addr_pointer uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .blk_load  (blk_load),
      .blk_val   (blk_val),
      .word_load (word_load),
      .word_val  (word_val),
      .step      (step),
      .rd_mode   (rd_mode),
      .addr      (addr)
   );

   // vector: req(4) bl(1) bv(3) wl(1) wv(8) st(1) rd(1) exp(11) = 30 bits
   localparam int NV = 18;
   localparam logic [29:0] VEC [NV] = '{
      {4'd2, 1'b1, 3'd5, 1'b0, 8'h00, 1'b0, 1'b0, 11'h500}, // R2 block load
      {4'd3, 1'b0, 3'd0, 1'b1, 8'h1E, 1'b0, 1'b0, 11'h51E}, // R3 word load
      {4'd4, 1'b0, 3'd0, 1'b0, 8'h00, 1'b1, 1'b0, 11'h51F}, // R4 in-page step
      {4'd4, 1'b0, 3'd0, 1'b0, 8'h00, 1'b1, 1'b0, 11'h500}, // R4 31 -> 0
      {4'd3, 1'b0, 3'd0, 1'b1, 8'h3F, 1'b0, 1'b0, 11'h53F}, // R3
      {4'd4, 1'b0, 3'd0, 1'b0, 8'h00, 1'b1, 1'b0, 11'h520}, // R4 63 -> 32
      {4'd6, 1'b0, 3'd6, 1'b0, 8'hAA, 1'b0, 1'b1, 11'h520}, // R6 idle, values ignored
      {4'd5, 1'b0, 3'd0, 1'b0, 8'h00, 1'b1, 1'b1, 11'h521}, // R5 read step
      {4'd3, 1'b0, 3'd0, 1'b1, 8'hFF, 1'b0, 1'b1, 11'h5FF}, // R3
      {4'd5, 1'b0, 3'd0, 1'b0, 8'h00, 1'b1, 1'b1, 11'h600}, // R5 block carry
      {4'd8, 1'b1, 3'd7, 1'b1, 8'hFF, 1'b0, 1'b0, 11'h7FF}, // R8 both loads
      {4'd5, 1'b0, 3'd0, 1'b0, 8'h00, 1'b1, 1'b1, 11'h000}, // R5 2047 -> 0
      {4'd7, 1'b1, 3'd2, 1'b0, 8'h00, 1'b1, 1'b0, 11'h200}, // R7 step lost to block load
      {4'd7, 1'b0, 3'd0, 1'b1, 8'h40, 1'b1, 1'b1, 11'h240}, // R7 step lost to word load
      {4'd4, 1'b0, 3'd0, 1'b0, 8'h00, 1'b1, 1'b0, 11'h241}, // R4
      {4'd2, 1'b1, 3'd3, 1'b0, 8'h00, 1'b0, 1'b0, 11'h341}, // R2 low bits kept
      {4'd6, 1'b0, 3'd1, 1'b0, 8'h12, 1'b0, 1'b0, 11'h341}, // R6 hold
      {4'd5, 1'b0, 3'd0, 1'b0, 8'h00, 1'b1, 1'b1, 11'h342}  // R5 resume from held pointer
   };

   task automatic check(input string req, input logic [10:0] exp);
      checks++;
      if (addr !== exp) begin
         errors++;
         $display("FAIL %s: addr=%h expected=%h", req, addr, exp);
      end
   endtask

   // drive at a falling edge; the design samples at the next rising edge
   task automatic drive(input logic bl, input logic [2:0] bv, input logic wl,
                        input logic [7:0] wv, input logic st, input logic rd);
      blk_load = bl; blk_val = bv; word_load = wl; word_val = wv; step = st; rd_mode = rd;
      @(negedge clk);
      blk_load = 1'b0; word_load = 1'b0; step = 1'b0;
   endtask

   initial begin
      logic [10:0] exp;
      repeat (3) @(negedge clk);
      check("R1", 11'h000);                        // R1 during reset
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", 11'h000);                        // R1 after release

      for (int i = 0; i < NV; i++) begin
         drive(VEC[i][25], VEC[i][24:22], VEC[i][21], VEC[i][20:13], VEC[i][12], VEC[i][11]);
         check($sformatf("R%0d", VEC[i][29:26]), VEC[i][10:0]);
      end

      // R4: a full page walk returns to the start, page field never moves
      drive(1'b1, 3'd4, 1'b1, 8'hB5, 1'b0, 1'b0);
      check("R8", 11'h4B5);
      exp = 11'h4B5;
      for (int k = 0; k < 32; k++) begin
         drive(1'b0, 3'd0, 1'b0, 8'h00, 1'b1, 1'b0);
         exp = {exp[10:5], exp[4:0] + 5'd1};
         check("R4", exp);
      end
      check("R4", 11'h4B5);

      // R5: a full array walk returns to the start
      exp = 11'h4B5;
      for (int k = 0; k < 2048; k++) begin
         drive(1'b0, 3'd0, 1'b0, 8'h00, 1'b1, 1'b1);
         exp = exp + 11'd1;
         check("R5", exp);
      end

      // R1: reset in mid-run clears the pointer
      drive(1'b1, 3'd6, 1'b1, 8'h77, 1'b0, 1'b0);
      check("R8", 11'h677);
      rst_n = 1'b0;
      #1;
      check("R1", 11'h000);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", 11'h000);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule